// File: doc/BRIEF.md
# UART Status Flag Register Front End

This block sits between a simple register bus and the line-side logic of a serial port. It keeps eight status flags, holds the last received word and the next word to transmit, and drives one interrupt line. The shift registers, the baud-rate generator and any pulse shaping live elsewhere. They report to this block through single-cycle event inputs: a word arrived (with framing and noise qualifiers), the line went idle, the transmitter took the held word, and the transmitter finished shifting.

Most flags are not cleared by writing to them. A read of the status register arms a clear sequence. The error flags and the idle flag are cleared when the very next bus access is a data read. The transmission-complete flag is cleared when that next access is a data write. Any other access disarms the sequence, and idle bus cycles leave it as it is. The receive-not-empty flag also clears on a data read by itself, and the transmit-empty flag clears on any data write.

A configuration register selects word length and parity and holds the interrupt enables. With parity on, the most significant bit of the word carries the parity bit. On transmit the block fills in that bit. On receive the block checks it and leaves it in the held word.

Top module: `uart_flag_regs`

## Requirements
- R1: After reset the status register (address 0) reads 0x00C0, meaning transmit-empty and transmission-complete are set and all other flags are clear. The configuration register (address 2) reads 0, and irq is low.
- R2: Status bit positions are: 7 transmit-empty (set by txLoad), 6 transmission-complete (set by txShiftDone), 5 receive-not-empty (set by an accepted word), 4 idle (set by lineIdle), 3 overrun, 2 noise, 1 framing and 0 parity error. The noise, framing and parity flags are set by an accepted word that carries that error.
- R3: A data read (address 1) clears receive-not-empty, with or without a preceding status read.
- R4: Overrun, noise, framing, parity and idle clear only on a data read that directly follows a status read as the next bus access. Any other access in between disarms the sequence. Idle bus cycles in between do not disarm it.
- R5: Transmission-complete clears only on a data write that directly follows a status read as the next bus access. A data write without that arming leaves it set.
- R6: Transmit-empty is cleared by any data write and by nothing else.
- R7: When a set event arrives in the same cycle as the access that would clear that flag, the flag stays set. A word that arrives during a data read is accepted and causes no overrun.
- R8: A word that arrives while receive-not-empty is set and no data read occurs in that cycle sets overrun. The word is discarded. The held word is kept, and the noise, framing and parity flags are not updated.
- R9: Configuration bit 2 selects 9-bit words when 1 and 8-bit words when 0. A data read returns the held word in bits 8:0. In 8-bit mode bit 8 reads 0.
- R10: Configuration bit 0 enables parity and bit 1 selects odd parity. With parity on, an accepted word whose XOR over its 9 (or 8) bits differs from the odd-select bit sets the parity flag. With parity off, the parity flag is never set.
- R11: A data write loads txWord with the written data masked to the word length. With parity on, the MSB (bit 8 or bit 7) is replaced by the bit that gives the word even or odd parity as configured.
- R12: irq is the registered OR of the enabled flags and rises one cycle after the flag. The enable bits are: configuration bit 3 transmit-empty, bit 4 transmission-complete, bit 5 receive-not-empty, bit 6 idle, bit 7 parity, and bit 8 a shared enable that covers framing, noise and overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | 0 status, 1 data, 2 configuration |
| busWdata | input | BUS_W | Write data |
| busRdata | output | BUS_W | Read data, valid in the access cycle |
| rxValid | input | 1 | Received word event |
| rxWord | input | WORD_W | Received word, parity bit at the MSB |
| rxFrameErr | input | 1 | Received word had a bad stop bit |
| rxNoise | input | 1 | Received word had noisy samples |
| lineIdle | input | 1 | Idle line detected event |
| txLoad | input | 1 | Transmitter took the held word |
| txShiftDone | input | 1 | Transmitter finished shifting |
| txWord | output | WORD_W | Formatted word to transmit |
| txWordValid | output | 1 | Held transmit word not yet taken |
| irq | output | 1 | Registered interrupt |

## Verification
The receive path is swept over every 9-bit word under all eight combinations of parity enable, odd select and word length. That sweep separates a wrong parity polarity, a wrong parity bit count and a missing MSB mask. The transmit formatting is swept over the same space. Directed sequences then drive the clearing orders: a status read directly before the data access, an access placed in between, and idle cycles placed in between. These sequences tell a correct arm bit from one that is never cleared or is cleared by idle cycles. Collision cases line up events with clearing accesses and send a second word into a full buffer, which separates event-wins priority and overrun handling from plain clearing.

// File: rtl/uflag_pkg.sv
package uflag_pkg;
  localparam int FLAG_N  = 8;
  // status bit positions (software decodes these)
  localparam int F_TXE   = 7;
  localparam int F_TC    = 6;
  localparam int F_RXNE  = 5;
  localparam int F_IDLE  = 4;
  localparam int F_ORE   = 3;
  localparam int F_NOISE = 2;
  localparam int F_FRAME = 1;
  localparam int F_PAR   = 0;
  localparam logic [FLAG_N-1:0] RST_FLAGS = 8'hC0;

  // configuration bit positions
  localparam int CFG_W     = 9;
  localparam int C_PEN     = 0;
  localparam int C_PODD    = 1;
  localparam int C_NINE    = 2;
  localparam int C_IE_TXE  = 3;
  localparam int C_IE_TC   = 4;
  localparam int C_IE_RXNE = 5;
  localparam int C_IE_IDLE = 6;
  localparam int C_IE_PAR  = 7;
  localparam int C_IE_ERR  = 8;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_DATA = 2'd1,
    REG_CFG  = 2'd2,
    REG_NONE = 2'd3
  } regSel_t;

  typedef struct packed {
    logic dataRd;
    logic dataWr;
    logic cfgWr;
    logic seqArmed;
  } busStrobe_t;
endpackage

// File: rtl/uflag_ctrl.sv
module uflag_ctrl
  import uflag_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strb,
  output regSel_t           rdSel
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(2);

  regSel_t hitSel;
  logic    statusRd;
  logic    armQ;

  always_comb begin
    if (busAddr == A_STAT)      hitSel = REG_STAT;
    else if (busAddr == A_DATA) hitSel = REG_DATA;
    else if (busAddr == A_CFG)  hitSel = REG_CFG;
    else                        hitSel = REG_NONE;
  end

  assign statusRd = busSel && !busWr && (hitSel == REG_STAT);

  // a status read arms; every other access disarms; idle cycles hold
  always_ff @(posedge clk) begin
    if (!rstN)       armQ <= 1'b0;
    else if (busSel) armQ <= statusRd;
  end

  always_comb begin
    strb.dataRd   = busSel && !busWr && (hitSel == REG_DATA);
    strb.dataWr   = busSel &&  busWr && (hitSel == REG_DATA);
    strb.cfgWr    = busSel &&  busWr && (hitSel == REG_CFG);
    strb.seqArmed = armQ;
    rdSel         = (busSel && !busWr) ? hitSel : REG_NONE;
  end
endmodule

// File: rtl/uflag_dpath.sv
module uflag_dpath
  import uflag_pkg::*;
#(
  parameter int WORD_W = 9,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  regSel_t           rdSel,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic              rxValid,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              rxFrameErr,
  input  logic              rxNoise,
  input  logic              lineIdle,
  input  logic              txLoad,
  input  logic              txShiftDone,
  output logic [BUS_W-1:0]  busRdata,
  output logic [WORD_W-1:0] txWord,
  output logic              txWordValid,
  output logic              irq,
  output logic [FLAG_N-1:0] flagVec,
  output logic [WORD_W-1:0] rxHeld
);
  localparam int SHORT_W = WORD_W - 1;

  logic [CFG_W-1:0]  cfgQ;
  logic [FLAG_N-1:0] flagQ, setVec, clrVec, enVec;
  logic [WORD_W-1:0] rxHoldQ, rxKeep, txHoldQ, txFmt, wrWord;
  logic              rxAccept, rxOverrun, rxXor, rxParBad, seqClr;
  logic              irqQ;
  logic              wdataUnused;

  assign wdataUnused = ^busWdata[BUS_W-1:WORD_W];
  assign wrWord      = busWdata[WORD_W-1:0];

  // receive acceptance: a read in the same cycle frees the buffer
  assign rxAccept  = rxValid && (!flagQ[F_RXNE] || strb.dataRd);
  assign rxOverrun = rxValid &&  flagQ[F_RXNE] && !strb.dataRd;
  assign rxXor     = cfgQ[C_NINE] ? ^rxWord : ^rxWord[SHORT_W-1:0];
  assign rxParBad  = cfgQ[C_PEN] && (rxXor != cfgQ[C_PODD]);
  assign rxKeep    = cfgQ[C_NINE] ? rxWord : {1'b0, rxWord[SHORT_W-1:0]};
  assign seqClr    = strb.dataRd && strb.seqArmed;

  // transmit formatting: parity bit replaces the MSB of the active length
  always_comb begin
    txFmt = wrWord;
    if (cfgQ[C_NINE]) begin
      if (cfgQ[C_PEN]) txFmt[WORD_W-1] = (^wrWord[WORD_W-2:0]) ^ cfgQ[C_PODD];
    end else begin
      txFmt[WORD_W-1] = 1'b0;
      if (cfgQ[C_PEN]) txFmt[WORD_W-2] = (^wrWord[WORD_W-3:0]) ^ cfgQ[C_PODD];
    end
  end

  always_comb begin
    setVec = '0;
    clrVec = '0;
    setVec[F_TXE]   = txLoad;
    clrVec[F_TXE]   = strb.dataWr;
    setVec[F_TC]    = txShiftDone;
    clrVec[F_TC]    = strb.dataWr && strb.seqArmed;
    setVec[F_RXNE]  = rxAccept;
    clrVec[F_RXNE]  = strb.dataRd;
    setVec[F_IDLE]  = lineIdle;
    setVec[F_ORE]   = rxOverrun;
    setVec[F_NOISE] = rxAccept && rxNoise;
    setVec[F_FRAME] = rxAccept && rxFrameErr;
    setVec[F_PAR]   = rxAccept && rxParBad;
    clrVec[F_IDLE]  = seqClr;
    clrVec[F_ORE]   = seqClr;
    clrVec[F_NOISE] = seqClr;
    clrVec[F_FRAME] = seqClr;
    clrVec[F_PAR]   = seqClr;
  end

  // one register per flag; set event has priority over clear
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[i] <= RST_FLAGS[i];
      else       flagQ[i] <= setVec[i] | (flagQ[i] & ~clrVec[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= '0;
      rxHoldQ <= '0;
      txHoldQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (strb.cfgWr)  cfgQ    <= busWdata[CFG_W-1:0];
      if (rxAccept)    rxHoldQ <= rxKeep;
      if (strb.dataWr) txHoldQ <= txFmt;
      irqQ <= |(flagQ & enVec);
    end
  end

  always_comb begin
    enVec          = '0;
    enVec[F_TXE]   = cfgQ[C_IE_TXE];
    enVec[F_TC]    = cfgQ[C_IE_TC];
    enVec[F_RXNE]  = cfgQ[C_IE_RXNE];
    enVec[F_IDLE]  = cfgQ[C_IE_IDLE];
    enVec[F_PAR]   = cfgQ[C_IE_PAR];
    enVec[F_ORE]   = cfgQ[C_IE_ERR];
    enVec[F_NOISE] = cfgQ[C_IE_ERR];
    enVec[F_FRAME] = cfgQ[C_IE_ERR];
  end

  always_comb begin
    unique case (rdSel)
      REG_STAT: busRdata = BUS_W'(flagQ);
      REG_DATA: busRdata = BUS_W'(rxHoldQ);
      REG_CFG:  busRdata = BUS_W'(cfgQ);
      default:  busRdata = '0;
    endcase
  end

  assign txWord      = txHoldQ;
  assign txWordValid = !flagQ[F_TXE];
  assign irq         = irqQ;
  assign flagVec     = flagQ;
  assign rxHeld      = rxHoldQ;
endmodule

// File: rtl/uart_flag_regs.sv
module uart_flag_regs
  import uflag_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int WORD_W = 9,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              rxValid,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              rxFrameErr,
  input  logic              rxNoise,
  input  logic              lineIdle,
  input  logic              txLoad,
  input  logic              txShiftDone,
  output logic [WORD_W-1:0] txWord,
  output logic              txWordValid,
  output logic              irq
);
  busStrobe_t        strb;
  regSel_t           rdSel;
  logic [FLAG_N-1:0] flagVec;
  logic [WORD_W-1:0] rxHeld;
  logic              seqArmed;

  assign seqArmed = strb.seqArmed;

  uflag_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .strb(strb), .rdSel(rdSel)
  );

  uflag_dpath #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .busWdata(busWdata),
    .rxValid(rxValid), .rxWord(rxWord), .rxFrameErr(rxFrameErr),
    .rxNoise(rxNoise), .lineIdle(lineIdle), .txLoad(txLoad),
    .txShiftDone(txShiftDone), .busRdata(busRdata), .txWord(txWord),
    .txWordValid(txWordValid), .irq(irq), .flagVec(flagVec), .rxHeld(rxHeld)
  );
endmodule

// File: rtl/uart_flag_regs_chk.sv
module uart_flag_regs_chk #(
  parameter int ADDR_W = 2,
  parameter int WORD_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              rxValid,
  input logic              irq,
  input logic [7:0]        flagVec,
  input logic              seqArmed,
  input logic [WORD_W-1:0] rxHeld
);
  logic sRd, dRd, dWr;
  assign sRd = busSel && !busWr && (busAddr == ADDR_W'(0));
  assign dRd = busSel && !busWr && (busAddr == ADDR_W'(1));
  assign dWr = busSel &&  busWr && (busAddr == ADDR_W'(1));

  // R3
  rxne_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagVec[5]) |-> $past(dRd));
  // R4
  err_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(flagVec[4:0]) & ~flagVec[4:0])) |-> $past(dRd && seqArmed));
  // R4
  arm_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    sRd |=> seqArmed);
  // R4
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !sRd) |=> !seqArmed);
  // R5
  tc_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagVec[6]) |-> $past(dWr && seqArmed));
  // R6
  txe_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagVec[7]) |-> $past(dWr));
  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && flagVec[5] && !dRd) |=> ($stable(rxHeld) && flagVec[3]));
  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(flagVec) != 8'h00));
endmodule

bind uart_flag_regs uart_flag_regs_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .rxValid(rxValid), .irq(irq), .flagVec(flagVec), .seqArmed(seqArmed),
  .rxHeld(rxHeld)
);

// File: tb/sim_uart_flag_regs.sv
`timescale 1ns/1ps
module sim_uart_flag_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        rxValid = 1'b0, rxFrameErr = 1'b0, rxNoise = 1'b0, lineIdle = 1'b0;
  logic [8:0]  rxWord = '0;
  logic        txLoad = 1'b0, txShiftDone = 1'b0;
  logic [8:0]  txWord;
  logic        txWordValid, irq;
  int          nChk = 0, nErr = 0;

  always #2.5 clk = ~clk;

  uart_flag_regs u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxWord(rxWord),
    .rxFrameErr(rxFrameErr), .rxNoise(rxNoise), .lineIdle(lineIdle),
    .txLoad(txLoad), .txShiftDone(txShiftDone), .txWord(txWord),
    .txWordValid(txWordValid), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1 busSel = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = v;
    @(posedge clk); #1 busSel = 0; busWr = 0;
  endtask

  task automatic pushRx(input logic [8:0] w, input logic fe, input logic ne);
    @(negedge clk); rxValid = 1; rxWord = w; rxFrameErr = fe; rxNoise = ne;
    @(posedge clk); #1 rxValid = 0; rxFrameErr = 0; rxNoise = 0;
  endtask

  // which: bit0 lineIdle, bit1 txLoad, bit2 txShiftDone
  task automatic pulse(input logic [2:0] which);
    @(negedge clk); lineIdle = which[0]; txLoad = which[1]; txShiftDone = which[2];
    @(posedge clk); #1 lineIdle = 0; txLoad = 0; txShiftDone = 0;
  endtask

  task automatic rdWithRx(input logic [8:0] w, output logic [15:0] d);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = 2'd1;
    rxValid = 1; rxWord = w; lineIdle = 1;
    #1 d = busRdata;
    @(posedge clk); #1 busSel = 0; rxValid = 0; lineIdle = 0;
  endtask

  task automatic wrWithLoad(input logic [15:0] v);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = 2'd1; busWdata = v; txLoad = 1;
    @(posedge clk); #1 busSel = 0; busWr = 0; txLoad = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    nErr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // reset state
    rd(2'd0, d); chk("R1 status", d, 16'h00C0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    rd(2'd2, d); chk("R1 cfg", d, 16'h0);

    // transmit flags
    wr(2'd1, 16'h0055);
    rd(2'd0, d); chk("R6/R5 unarmed write", d, 16'h0040);
    wr(2'd1, 16'h0033);
    rd(2'd0, d); chk("R5 armed write", d, 16'h0000);
    chk("R11 txWord plain", {7'd0, txWord}, 16'h0033);
    pulse(3'b010);
    rd(2'd0, d); chk("R2 txLoad", d, 16'h0080);
    pulse(3'b100);
    rd(2'd0, d); chk("R2 txShiftDone", d, 16'h00C0);

    // receive-not-empty cleared by a lone data read
    pushRx(9'h1A5, 0, 0);
    rd(2'd2, d);
    rd(2'd1, d); chk("R9 8-bit masked", d, 16'h00A5);
    rd(2'd0, d); chk("R3 lone read", d, 16'h00C0);

    // error flags: intervening access keeps them, idle gap does not disarm
    pushRx(9'h03C, 1, 1);
    pulse(3'b001);
    rd(2'd2, d);
    rd(2'd1, d); chk("R9 data", d, 16'h003C);
    rd(2'd0, d); chk("R4 not armed", d, 16'h00D6);
    repeat (3) @(posedge clk);
    rd(2'd1, d); chk("R9 held word", d, 16'h003C);
    rd(2'd0, d); chk("R4 armed clear", d, 16'h00C0);

    // overrun
    pushRx(9'h0A5, 0, 0);
    pushRx(9'h15A, 1, 0);
    rd(2'd0, d); chk("R8 overrun flags", d, 16'h00E8);
    rd(2'd1, d); chk("R8 held word", d, 16'h00A5);
    rd(2'd0, d); chk("R4 overrun clear", d, 16'h00C0);

    // events collide with clearing accesses
    pushRx(9'h011, 0, 0);
    pulse(3'b001);
    rd(2'd0, d); chk("R2 rx+idle", d, 16'h00F0);
    rdWithRx(9'h022, d); chk("R7 old word", d, 16'h0011);
    rd(2'd0, d); chk("R7 flags kept", d, 16'h00F0);
    rd(2'd1, d); chk("R7 new word", d, 16'h0022);
    rd(2'd0, d); chk("R4 clear after", d, 16'h00C0);
    wrWithLoad(16'h0001);
    rd(2'd0, d); chk("R7 txe kept", d, 16'h0080);
    pulse(3'b100);

    // interrupt
    wr(2'd2, 16'h0020);
    pushRx(9'h001, 0, 0);
    chk("R12 latency", {15'd0, irq}, 16'h0);
    @(posedge clk); #1 chk("R12 rxne irq", {15'd0, irq}, 16'h1);
    wr(2'd2, 16'h0100);
    repeat (2) @(posedge clk); #1 chk("R12 masked", {15'd0, irq}, 16'h0);
    pushRx(9'h002, 0, 0);
    repeat (2) @(posedge clk); #1 chk("R12 err overrun", {15'd0, irq}, 16'h1);
    rd(2'd0, d); rd(2'd1, d);
    repeat (2) @(posedge clk); #1 chk("R12 cleared", {15'd0, irq}, 16'h0);
    wr(2'd2, 16'h0008);
    repeat (2) @(posedge clk); #1 chk("R12 txe irq", {15'd0, irq}, 16'h1);
    wr(2'd2, 16'h0000);
    repeat (2) @(posedge clk); #1 chk("R12 off", {15'd0, irq}, 16'h0);

    // receive sweep: every word, every parity/length setting
    for (int c = 0; c < 8; c++) begin
      wr(2'd2, 16'(c));
      for (int w = 0; w < 512; w++) begin
        logic [8:0] ww;
        logic pen, odd, nine, x, bad;
        logic [15:0] expD;
        ww = 9'(w); pen = c[0]; odd = c[1]; nine = c[2];
        x = nine ? ^ww : ^ww[7:0];
        bad = pen && (x != odd);
        expD = nine ? {7'd0, ww} : {8'd0, ww[7:0]};
        pushRx(ww, 0, 0);
        rd(2'd0, d); chk("R10 parity flag", d & 16'h0021, {10'd0, 1'b1, 4'd0, bad});
        rd(2'd1, d); chk("R9 rx word", d, expD);
      end
    end

    // transmit sweep
    for (int c = 0; c < 8; c++) begin
      wr(2'd2, 16'(c));
      for (int w = 0; w < 512; w++) begin
        logic [8:0] ww, e;
        ww = 9'(w);
        if (c[2]) begin
          e = ww;
          if (c[0]) e[8] = (^ww[7:0]) ^ c[1];
        end else begin
          e = {1'b0, ww[7:0]};
          if (c[0]) e[7] = (^ww[6:0]) ^ c[1];
        end
        wr(2'd1, 16'(w));
        chk("R11 tx format", {7'd0, txWord}, {7'd0, e});
      end
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule